// File: doc/BRIEF.md
# Prioritized External Interrupt Selector

This block sits next to a processor core's trap logic and turns a vector of level-sensitive interrupt request lines into a single pending trap code. Every cycle it finds the highest asserted request level, numbered 1 to 15, and forms the external-interrupt trap code for that level: the group base 0x10 OR'd with the level in the low four bits, giving 0x11 to 0x1F. Bit 0 of the request vector is never an interrupt source.

The core presents the trap code it currently has pending, which may come from any source, with zero meaning none. The selector replaces that code only when it is empty or already belongs to the external-interrupt group, so a synchronous exception that is already pending is never displaced. A hard-interrupt request strobe is raised only when the selected code differs from the one the core holds. When every line has dropped while an external-interrupt code is pending, the code returns to zero and a clear strobe tells the core to withdraw its request. The trap-entry logic reports the level it has taken on an acknowledge input, which is forwarded to an external interrupt controller and does not change the pending code.

Top module: `ext_irq_sel`

## Requirements
- R1: While `rst` is high at a clock edge, `pend_code` becomes 0 and `hard_req`, `clr_strobe` and `ack_out_valid` become 0.
- R2: Bit 0 of `irq_lvl` is ignored: a vector with only bit 0 set behaves exactly like an all-zero vector.
- R3: When several of lines 1 to 15 are high, the highest-numbered one wins, and the selected code is 0x10 OR'd with that level (level 2 gives 0x12, level 15 gives 0x1F).
- R4: A selection is loaded into `pend_code` at the next clock edge only when `core_code` is 0 or `core_code[7:4]` equals 0x1 (the group, including the bare base 0x10).
- R5: When `core_code` is non-zero and `core_code[7:4]` is not 0x1, `pend_code` holds its value and neither strobe is raised.
- R6: `hard_req` is high in the cycle after an edge at which a selection was loaded and the selected code differed from `core_code`; it is low when they were equal.
- R7: When no line from 1 to 15 is high and `core_code[7:4]` is 0x1, `pend_code` becomes 0 and `clr_strobe` is high after the next edge.
- R8: When no line from 1 to 15 is high and `core_code` is 0 or outside the group, `pend_code` holds and `clr_strobe` stays low.
- R9: An acknowledge (`ack_valid` high with `ack_level`) appears on `ack_out_valid`/`ack_out_level` one edge later and leaves `pend_code` unchanged.
- R10: `hard_req` and `clr_strobe` are never high together, and `pend_code` is always 0 or a group code with a non-zero level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lvl | input | 16 | Level-sensitive request lines; bit 0 unused |
| core_code | input | 8 | Trap code currently pending in the core, 0 for none |
| ack_valid | input | 1 | Trap entry has taken an external interrupt |
| ack_level | input | 4 | Level that was taken |
| pend_code | output | 8 | Pending external-interrupt trap code |
| hard_req | output | 1 | Hard-interrupt request strobe toward the core |
| clr_strobe | output | 1 | Withdraw-request strobe toward the core |
| ack_out_valid | output | 1 | Forwarded acknowledge valid |
| ack_out_level | output | 4 | Forwarded acknowledged level |

## Verification
The bench builds the block with its defaults: fifteen levels, an 8-bit trap code with group base 0x10, and a registered acknowledge path. With these values every level from 1 to 15 and its code can be reached directly, and `core_code` can be driven independently of `pend_code`, which brings within reach the cases where the core holds a non-group code, the bare group base, or a group code that differs from the new selection.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

   // True when the code lies in the group whose base shares the upper bits.
   function automatic logic grp_hit(input logic [31:0] code,
                                    input logic [31:0] base,
                                    input int unsigned low_w);
      return (code >> low_w) == (base >> low_w);
   endfunction

   typedef enum logic {ACK_PASS = 1'b0, ACK_REGD = 1'b1} ack_mode_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned LEVELS = 15,
   parameter int unsigned LVL_W  = 4
) (
   input  logic [LEVELS-1:0] req,   // req[i] is level i+1
   output logic              any,
   output logic [LVL_W-1:0]  lvl
);
   always_comb begin
      any = 1'b0;
      lvl = '0;
      for (int i = 0; i < LEVELS; i++) begin
         if (req[i]) begin
            any = 1'b1;
            lvl = LVL_W'(i + 1);
         end
      end
   end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
   parameter int unsigned        CODE_W   = 8,
   parameter int unsigned        LVL_W    = 4,
   parameter logic [CODE_W-1:0]  GRP_BASE = 8'h10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_any,
   input  logic [LVL_W-1:0]  sel_lvl,
   input  logic [CODE_W-1:0] core_code,
   output logic [CODE_W-1:0] pend_code,
   output logic              hard_req,
   output logic              clr_strobe
);
   import irq_sel_pkg::*;

   logic [CODE_W-1:0] sel_code;
   logic              core_in_grp;
   logic              may_load;
   logic              do_load;
   logic              do_clear;

   assign sel_code    = GRP_BASE | {{(CODE_W-LVL_W){1'b0}}, sel_lvl};
   assign core_in_grp = grp_hit(32'(core_code), 32'(GRP_BASE), LVL_W);
   assign may_load    = (core_code == '0) || core_in_grp;
   assign do_load     = sel_any && may_load;
   assign do_clear    = !sel_any && core_in_grp;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_code  <= '0;
         hard_req   <= 1'b0;
         clr_strobe <= 1'b0;
      end else begin
         hard_req   <= do_load && (sel_code != core_code);
         clr_strobe <= do_clear;
         if (do_load)
            pend_code <= sel_code;
         else if (do_clear)
            pend_code <= '0;
      end
   end
endmodule

// File: rtl/irq_ack_fwd.sv
module irq_ack_fwd #(
   parameter int unsigned          LVL_W = 4,
   parameter irq_sel_pkg::ack_mode_e MODE = irq_sel_pkg::ACK_REGD
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ack_valid,
   input  logic [LVL_W-1:0] ack_level,
   output logic             out_valid,
   output logic [LVL_W-1:0] out_level
);
   generate
      if (MODE == irq_sel_pkg::ACK_REGD) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               out_valid <= 1'b0;
               out_level <= '0;
            end else begin
               out_valid <= ack_valid;
               out_level <= ack_valid ? ack_level : '0;
            end
         end
      end else begin : g_pass
         logic clk_unused;
         assign clk_unused = clk;
         assign out_valid  = ack_valid && !rst;
         assign out_level  = out_valid ? ack_level : '0;
      end
   endgenerate
endmodule

// File: rtl/ext_irq_sel.sv
module ext_irq_sel #(
   parameter int unsigned             LEVELS   = 15,
   parameter int unsigned             CODE_W   = 8,
   parameter logic [CODE_W-1:0]       GRP_BASE = 8'h10,
   parameter irq_sel_pkg::ack_mode_e  ACK_MODE = irq_sel_pkg::ACK_REGD,
   localparam int unsigned            LVL_W    = $clog2(LEVELS + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LEVELS:0]   irq_lvl,
   input  logic [CODE_W-1:0] core_code,
   input  logic              ack_valid,
   input  logic [LVL_W-1:0]  ack_level,
   output logic [CODE_W-1:0] pend_code,
   output logic              hard_req,
   output logic              clr_strobe,
   output logic              ack_out_valid,
   output logic [LVL_W-1:0]  ack_out_level
);
   initial begin
      if (LEVELS < 1)
         $error("LEVELS must be at least 1");
      if (CODE_W <= LVL_W)
         $error("CODE_W must exceed the level field width");
      if (GRP_BASE[LVL_W-1:0] != '0)
         $error("GRP_BASE must have a zero level field");
      if (GRP_BASE == '0)
         $error("GRP_BASE must be non-zero");
   end

   logic             bit0_unused;
   logic             sel_any;
   logic [LVL_W-1:0] sel_lvl;

   assign bit0_unused = irq_lvl[0];

   irq_prio_enc #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_enc (
      .req (irq_lvl[LEVELS:1]),
      .any (sel_any),
      .lvl (sel_lvl)
   );

   irq_pend_ctrl #(.CODE_W(CODE_W), .LVL_W(LVL_W), .GRP_BASE(GRP_BASE)) u_pend (
      .clk        (clk),
      .rst        (rst),
      .sel_any    (sel_any),
      .sel_lvl    (sel_lvl),
      .core_code  (core_code),
      .pend_code  (pend_code),
      .hard_req   (hard_req),
      .clr_strobe (clr_strobe)
   );

   irq_ack_fwd #(.LVL_W(LVL_W), .MODE(ACK_MODE)) u_ack (
      .clk       (clk),
      .rst       (rst),
      .ack_valid (ack_valid),
      .ack_level (ack_level),
      .out_valid (ack_out_valid),
      .out_level (ack_out_level)
   );
endmodule

// File: rtl/ext_irq_sel_chk.sv
module ext_irq_sel_chk #(
   parameter int unsigned       LEVELS   = 15,
   parameter int unsigned       CODE_W   = 8,
   parameter logic [CODE_W-1:0] GRP_BASE = 8'h10,
   parameter int unsigned       LVL_W    = 4,
   parameter bit                ACK_REG  = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [LEVELS:0]   irq_lvl,
   input logic [CODE_W-1:0] core_code,
   input logic              ack_valid,
   input logic [LVL_W-1:0]  ack_level,
   input logic [CODE_W-1:0] pend_code,
   input logic              hard_req,
   input logic              clr_strobe,
   input logic              ack_out_valid,
   input logic [LVL_W-1:0]  ack_out_level
);
   logic lines_idle, core_grp, pend_grp;
   assign lines_idle = (irq_lvl[LEVELS:1] == '0);
   assign core_grp   = (core_code[CODE_W-1:LVL_W] == GRP_BASE[CODE_W-1:LVL_W]);
   assign pend_grp   = (pend_code[CODE_W-1:LVL_W] == GRP_BASE[CODE_W-1:LVL_W]);

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (pend_code == '0 && !hard_req && !clr_strobe && !ack_out_valid)); // R1

   AST_FOREIGN_HOLD: assert property (@(posedge clk) disable iff (rst)
      (core_code != '0 && !core_grp) |=> ($stable(pend_code) && !hard_req && !clr_strobe)); // R5

   AST_IDLE_WITHDRAW: assert property (@(posedge clk) disable iff (rst)
      (lines_idle && core_grp) |=> (pend_code == '0 && clr_strobe)); // R7

   AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
      (lines_idle && !core_grp) |=> ($stable(pend_code) && !clr_strobe && !hard_req)); // R8

   AST_LOAD_GROUP: assert property (@(posedge clk) disable iff (rst)
      (!lines_idle && (core_code == '0 || core_grp)) |=> (pend_grp && pend_code[LVL_W-1:0] != '0)); // R4

   AST_REQ_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
      hard_req |-> (pend_code != $past(core_code))); // R6

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(hard_req && clr_strobe)); // R10

   AST_CODE_SHAPE: assert property (@(posedge clk) disable iff (rst)
      (pend_code == '0) || (pend_grp && pend_code[LVL_W-1:0] != '0)); // R10

   generate
      if (ACK_REG) begin : g_ack_chk
         AST_ACK_FORWARD: assert property (@(posedge clk) disable iff (rst)
            ack_valid |=> (ack_out_valid && ack_out_level == $past(ack_level))); // R9
      end
   endgenerate
endmodule

bind ext_irq_sel ext_irq_sel_chk #(
   .LEVELS   (LEVELS),
   .CODE_W   (CODE_W),
   .GRP_BASE (GRP_BASE),
   .LVL_W    (LVL_W),
   .ACK_REG  (ACK_MODE == irq_sel_pkg::ACK_REGD)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .irq_lvl       (irq_lvl),
   .core_code     (core_code),
   .ack_valid     (ack_valid),
   .ack_level     (ack_level),
   .pend_code     (pend_code),
   .hard_req      (hard_req),
   .clr_strobe    (clr_strobe),
   .ack_out_valid (ack_out_valid),
   .ack_out_level (ack_out_level)
);

// File: tb/ext_irq_sel_tb_top.sv
module ext_irq_sel_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [15:0] irq_lvl = '0;
   logic [7:0] core_code = '0;
   logic       ack_valid = 1'b0;
   logic [3:0] ack_level = '0;
   logic [7:0] pend_code;
   logic       hard_req, clr_strobe, ack_out_valid;
   logic [3:0] ack_out_level;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   ext_irq_sel dut_i (
      .clk(clk), .rst(rst), .irq_lvl(irq_lvl), .core_code(core_code),
      .ack_valid(ack_valid), .ack_level(ack_level), .pend_code(pend_code),
      .hard_req(hard_req), .clr_strobe(clr_strobe),
      .ack_out_valid(ack_out_valid), .ack_out_level(ack_out_level)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Applied in order from reset: irq, core, expected pend, req, clr, requirement.
   localparam int NVEC = 15;
   localparam logic [41:0] VEC [NVEC] = '{
      {16'h0001, 8'h00, 8'h00, 1'b0, 1'b0, 8'd2},   // R2 bit 0 alone
      {16'h0004, 8'h00, 8'h12, 1'b1, 1'b0, 8'd3},   // R3 level 2
      {16'h0004, 8'h12, 8'h12, 1'b0, 1'b0, 8'd6},   // R6 same code, no request
      {16'h8006, 8'h12, 8'h1F, 1'b1, 1'b0, 8'd3},   // R3 highest wins
      {16'h8006, 8'h07, 8'h1F, 1'b0, 1'b0, 8'd5},   // R5 foreign code blocks
      {16'h0000, 8'h07, 8'h1F, 1'b0, 1'b0, 8'd8},   // R8 idle, foreign core
      {16'h0000, 8'h1F, 8'h00, 1'b0, 1'b1, 8'd7},   // R7 withdraw
      {16'h0000, 8'h00, 8'h00, 1'b0, 1'b0, 8'd8},   // R8 idle, empty core
      {16'h0A00, 8'h00, 8'h1B, 1'b1, 1'b0, 8'd3},   // R3 levels 9 and 11
      {16'h0A00, 8'h15, 8'h1B, 1'b1, 1'b0, 8'd4},   // R4 group code replaced
      {16'h0A00, 8'h1B, 8'h1B, 1'b0, 1'b0, 8'd6},   // R6 unchanged
      {16'h0001, 8'h1B, 8'h00, 1'b0, 1'b1, 8'd2},   // R2 bit 0 counts as idle
      {16'h0002, 8'h20, 8'h00, 1'b0, 1'b0, 8'd5},   // R5 code 0x20 outside group
      {16'h0002, 8'h10, 8'h11, 1'b1, 1'b0, 8'd4},   // R4 bare base is in group
      {16'h0000, 8'h10, 8'h00, 1'b0, 1'b1, 8'd7}    // R7 bare base withdrawn
   };

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1", "pend_code", 32'(pend_code), 32'h00);
      check("R1", "hard_req", 32'(hard_req), 32'h0);
      check("R1", "clr_strobe", 32'(clr_strobe), 32'h0);
      check("R1", "ack_out_valid", 32'(ack_out_valid), 32'h0);
      rst = 1'b0;

      for (int v = 0; v < NVEC; v++) begin
         irq_lvl   = VEC[v][41:26];
         core_code = VEC[v][25:18];
         @(posedge clk);
         @(negedge clk);
         check($sformatf("R%0d", VEC[v][7:0]), $sformatf("vec%0d pend_code", v),
               32'(pend_code), 32'(VEC[v][17:10]));
         check($sformatf("R%0d", VEC[v][7:0]), $sformatf("vec%0d hard_req", v),
               32'(hard_req), 32'(VEC[v][9]));
         check($sformatf("R%0d", VEC[v][7:0]), $sformatf("vec%0d clr_strobe", v),
               32'(clr_strobe), 32'(VEC[v][8]));
         check("R10", $sformatf("vec%0d strobe overlap", v),
               32'(hard_req && clr_strobe), 32'h0);
      end

      // R9: acknowledge forwarded, pending code untouched
      irq_lvl   = 16'h0020;   // level 5
      core_code = 8'h15;
      @(posedge clk);
      @(negedge clk);
      check("R3", "level 5 pend", 32'(pend_code), 32'h15);
      ack_valid = 1'b1;
      ack_level = 4'd5;
      @(posedge clk);
      @(negedge clk);
      ack_valid = 1'b0;
      ack_level = 4'd0;
      check("R9", "ack_out_valid", 32'(ack_out_valid), 32'h1);
      check("R9", "ack_out_level", 32'(ack_out_level), 32'h5);
      check("R9", "pend after ack", 32'(pend_code), 32'h15);
      @(posedge clk);
      @(negedge clk);
      check("R9", "ack_out_valid drop", 32'(ack_out_valid), 32'h0);

      // R1: reset mid-run with a pending code
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R1", "pend after reset", 32'(pend_code), 32'h00);
      check("R1", "hard_req after reset", 32'(hard_req), 32'h0);
      rst = 1'b0;

      // R3: each single level maps to its code
      core_code = 8'h00;
      for (int l = 1; l < 16; l++) begin
         irq_lvl = 16'(1 << l);
         @(posedge clk);
         @(negedge clk);
         check("R3", $sformatf("single level %0d", l), 32'(pend_code), 32'(8'h10 | l));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule